// File: doc/BRIEF.md
# Size-Aware Operand Register File

This block stores the sixteen general registers of a 32-bit processor core: eight data registers and eight address registers, all 32 bits wide. Every access carries an operation size of byte, word or long. A data register changes only in the low portion that a short write targets. An address register is always rewritten in full: a word value is sign-extended first, and a byte-sized write is refused and flagged. Each of the two combinational read ports returns the operand view that fits its size.

The single write port and a separate half-swap port update the file on the rising clock edge. The half-swap port exchanges the upper and lower 16-bit halves of one data register. A read in the same cycle as an update sees the old contents. Execution logic places the file between operand decode and writeback.

Top module: `cpu_regfile`

## Requirements
- R1: A synchronous active-high reset clears every register to zero.
- R2: A write to a data register with size byte changes bits 7:0 only, size word changes bits 15:0 only, and size long changes all 32 bits. Bits outside the written portion keep their value.
- R3: Size codes are 0 byte, 1 word and 2 long. A data-register read returns bits 7:0 for byte and bits 15:0 for word, with the remaining upper bits zero. For long it returns all 32 bits.
- R4: A word write to an address register stores bit 15 of the value copied into bits 31:16. A long write stores the value unchanged.
- R5: A byte write to an address register leaves that register unchanged and raises `size_err` combinationally in the same cycle.
- R6: An address-register read returns the low 16 bits, zero-extended, for word size and all 32 bits for long size. For byte size it returns zero.
- R7: With `swap_en` high, data register `swap_sel` takes its old bits 15:0 into bits 31:16 and its old bits 31:16 into bits 15:0 at the next edge.
- R8: When a write and a swap target the same data register in the same cycle, the write is applied and the swap is dropped. When they target different registers, both take effect.
- R9: A read of a register in the cycle it is written returns the value from before the write. The new value is visible from the next cycle.
- R10: A select is 4 bits wide. Bit 3 picks the address bank (1) or the data bank (0), and bits 2:0 pick the register. Size code 3 behaves as long.
- R11: The two read ports are independent, and each returns its own register and size view in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd0_sel | input | 4 | Read port 0 register select |
| rd0_size | input | 2 | Read port 0 operation size |
| rd0_data | output | 32 | Read port 0 operand view |
| rd1_sel | input | 4 | Read port 1 register select |
| rd1_size | input | 2 | Read port 1 operation size |
| rd1_data | output | 32 | Read port 1 operand view |
| wr_en | input | 1 | Write enable |
| wr_sel | input | 4 | Write register select |
| wr_size | input | 2 | Write operation size |
| wr_data | input | 32 | Write value |
| swap_en | input | 1 | Half-swap enable |
| swap_sel | input | 3 | Data register to half-swap |
| size_err | output | 1 | Byte write aimed at an address register |

## Verification
Data registers are first loaded with a long pattern and then overwritten with byte and word values that have distinct content in every byte. This separates a correct partial merge from a full overwrite or from a merge at the wrong width. Address registers receive word values with bit 15 set and with bit 15 clear, which separates sign extension from zero extension. They also receive byte writes, which must leave the register untouched. Swap runs alone, together with a write to the same register, and together with a write to another register. A long run of pseudo-random selects, sizes and values then compares both read views and the error flag each cycle against a behavioural model, including reads of the register being written in that same cycle.

// File: rtl/regfile_pkg.sv
package regfile_pkg;

    localparam int WORD_BITS = 32;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_RSVD = 2'd3
    } opsize_e;

    // Operand view of a register for a given size, upper bits cleared
    function automatic logic [WORD_BITS-1:0] low_view(
        input logic [WORD_BITS-1:0] v,
        input opsize_e              sz
    );
        case (sz)
            SZ_BYTE: low_view = {{(WORD_BITS-8){1'b0}}, v[7:0]};
            SZ_WORD: low_view = {{(WORD_BITS-16){1'b0}}, v[15:0]};
            default: low_view = v;
        endcase
    endfunction

    function automatic logic [WORD_BITS-1:0] half_swap(input logic [WORD_BITS-1:0] v);
        half_swap = {v[15:0], v[WORD_BITS-1:16]};
    endfunction

endpackage

// File: rtl/rf_write_merge.sv
module rf_write_merge
    import regfile_pkg::*;
(
    input  logic [WORD_BITS-1:0] cur_val,
    input  logic [WORD_BITS-1:0] new_val,
    input  opsize_e              size,
    input  logic                 to_addr,
    output logic [WORD_BITS-1:0] merged,
    output logic                 refused
);
    always_comb begin
        merged  = cur_val;
        refused = 1'b0;
        if (to_addr) begin
            case (size)
                SZ_BYTE: refused = 1'b1;
                SZ_WORD: merged  = {{(WORD_BITS-16){new_val[15]}}, new_val[15:0]};
                default: merged  = new_val;
            endcase
        end else begin
            case (size)
                SZ_BYTE: merged = {cur_val[WORD_BITS-1:8], new_val[7:0]};
                SZ_WORD: merged = {cur_val[WORD_BITS-1:16], new_val[15:0]};
                default: merged = new_val;
            endcase
        end
    end
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
    import regfile_pkg::*;
#(
    parameter int NREGS = 16,
    localparam int SEL_W = $clog2(NREGS)
) (
    input  logic [WORD_BITS-1:0] bank [NREGS],
    input  logic [SEL_W-1:0]     sel,
    input  opsize_e              size,
    output logic [WORD_BITS-1:0] view
);
    logic from_addr;
    assign from_addr = sel[SEL_W-1];

    always_comb begin
        if (from_addr && size == SZ_BYTE)
            view = '0;
        else
            view = low_view(bank[sel], size);
    end
endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile
    import regfile_pkg::*;
#(
    parameter int BANK_REGS = 8,
    localparam int NREGS  = 2 * BANK_REGS,
    localparam int SEL_W  = $clog2(NREGS),
    localparam int BSEL_W = $clog2(BANK_REGS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [SEL_W-1:0]     rd0_sel,
    input  logic [1:0]           rd0_size,
    output logic [WORD_BITS-1:0] rd0_data,
    input  logic [SEL_W-1:0]     rd1_sel,
    input  logic [1:0]           rd1_size,
    output logic [WORD_BITS-1:0] rd1_data,
    input  logic                 wr_en,
    input  logic [SEL_W-1:0]     wr_sel,
    input  logic [1:0]           wr_size,
    input  logic [WORD_BITS-1:0] wr_data,
    input  logic                 swap_en,
    input  logic [BSEL_W-1:0]    swap_sel,
    output logic                 size_err
);
    logic [WORD_BITS-1:0] regs [NREGS];
    logic [WORD_BITS-1:0] wr_merged;
    logic                 wr_refused;

    rf_write_merge u_merge (
        .cur_val (regs[wr_sel]),
        .new_val (wr_data),
        .size    (opsize_e'(wr_size)),
        .to_addr (wr_sel[SEL_W-1]),
        .merged  (wr_merged),
        .refused (wr_refused)
    );

    assign size_err = wr_en && wr_refused;

    rf_read_port #(.NREGS(NREGS)) u_rd0 (
        .bank (regs),
        .sel  (rd0_sel),
        .size (opsize_e'(rd0_size)),
        .view (rd0_data)
    );

    rf_read_port #(.NREGS(NREGS)) u_rd1 (
        .bank (regs),
        .sel  (rd1_sel),
        .size (opsize_e'(rd1_size)),
        .view (rd1_data)
    );

    for (genvar i = 0; i < NREGS; i++) begin : g_reg
        logic wr_hit;
        logic swap_hit;
        assign wr_hit = wr_en && (wr_sel == SEL_W'(i)) && !wr_refused;
        if (i < BANK_REGS) begin : g_data
            assign swap_hit = swap_en && (swap_sel == BSEL_W'(i));
        end else begin : g_addr
            assign swap_hit = 1'b0;
        end

        always_ff @(posedge clk) begin
            if (rst)
                regs[i] <= '0;
            else if (wr_hit)
                regs[i] <= wr_merged;
            else if (swap_hit)
                regs[i] <= half_swap(regs[i]);
        end

        // R1
        reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
            $fell(rst) |-> regs[i] == '0);

        if (i < BANK_REGS) begin : g_data_chk
            // R2
            data_byte_keep_chk: assert property (@(posedge clk) disable iff (rst)
                (wr_en && wr_sel == SEL_W'(i) && wr_size == SZ_BYTE) |=>
                (regs[i][WORD_BITS-1:8] == $past(regs[i][WORD_BITS-1:8]) &&
                 regs[i][7:0] == $past(wr_data[7:0])));
            // R7
            swap_halves_chk: assert property (@(posedge clk) disable iff (rst)
                (swap_en && swap_sel == BSEL_W'(i) && !(wr_en && wr_sel == SEL_W'(i))) |=>
                (regs[i] == {$past(regs[i][15:0]), $past(regs[i][WORD_BITS-1:16])}));
        end else begin : g_addr_chk
            // R5
            addr_byte_refuse_chk: assert property (@(posedge clk) disable iff (rst)
                (wr_en && wr_sel == SEL_W'(i) && wr_size == SZ_BYTE) |=> $stable(regs[i]));
            // R4
            addr_word_sext_chk: assert property (@(posedge clk) disable iff (rst)
                (wr_en && wr_sel == SEL_W'(i) && wr_size == SZ_WORD) |=>
                (regs[i] == {{(WORD_BITS-16){$past(wr_data[15])}}, $past(wr_data[15:0])}));
        end
    end
endmodule

// File: tb/sim_cpu_regfile.sv
module sim_cpu_regfile;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  rd0_sel = '0, rd1_sel = '0, wr_sel = '0;
    logic [1:0]  rd0_size = 2'd2, rd1_size = 2'd2, wr_size = 2'd2;
    logic [31:0] rd0_data, rd1_data, wr_data = '0;
    logic        wr_en = 1'b0, swap_en = 1'b0, size_err;
    logic [2:0]  swap_sel = '0;

    int checks = 0;
    int errors = 0;
    logic [31:0] mdl [16];
    logic [31:0] s0, s1;
    logic        serr;

    always #5 clk = ~clk;

    cpu_regfile u0 (
        .clk(clk), .rst(rst),
        .rd0_sel(rd0_sel), .rd0_size(rd0_size), .rd0_data(rd0_data),
        .rd1_sel(rd1_sel), .rd1_size(rd1_size), .rd1_data(rd1_data),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_size(wr_size), .wr_data(wr_data),
        .swap_en(swap_en), .swap_sel(swap_sel), .size_err(size_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mread(input logic [3:0] s, input logic [1:0] z);
        logic [31:0] v = mdl[s];
        if (z == 2'd0) return s[3] ? 32'h0 : (v & 32'h0000_00FF);
        if (z == 2'd1) return v & 32'h0000_FFFF;
        return v;
    endfunction

    task automatic model_update();
        logic wrote_swapped = 1'b0;
        if (wr_en) begin
            if (wr_sel[3]) begin
                if (wr_size == 2'd1) mdl[wr_sel] = {{16{wr_data[15]}}, wr_data[15:0]};
                else if (wr_size != 2'd0) mdl[wr_sel] = wr_data;
            end else begin
                if (wr_size == 2'd0) mdl[wr_sel][7:0] = wr_data[7:0];
                else if (wr_size == 2'd1) mdl[wr_sel][15:0] = wr_data[15:0];
                else mdl[wr_sel] = wr_data;
            end
            wrote_swapped = (wr_sel == {1'b0, swap_sel});
        end
        if (swap_en && !wrote_swapped)
            mdl[{1'b0, swap_sel}] = {mdl[{1'b0, swap_sel}][15:0], mdl[{1'b0, swap_sel}][31:16]};
    endtask

    // Called at a negedge with inputs set; compares, advances one edge, returns at next negedge
    task automatic tick();
        #1;
        s0 = rd0_data; s1 = rd1_data; serr = size_err;
        chk("R11 port0 model", s0, mread(rd0_sel, rd0_size));
        chk("R11 port1 model", s1, mread(rd1_sel, rd1_size));
        chk("R5 size_err model", {31'b0, serr}, {31'b0, wr_en && wr_sel[3] && wr_size == 2'd0});
        @(posedge clk); #1;
        model_update();
        @(negedge clk);
        wr_en = 1'b0; swap_en = 1'b0;
    endtask

    task automatic wr(input logic [3:0] s, input logic [1:0] z, input logic [31:0] d);
        wr_en = 1'b1; wr_sel = s; wr_size = z; wr_data = d;
        tick();
    endtask

    task automatic peek(input logic [3:0] s, input logic [1:0] z);
        rd0_sel = s; rd0_size = z;
        tick();
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) mdl[i] = '0;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        peek(4'h3, 2'd2); chk("R1 data reset", s0, 32'h0);
        peek(4'hA, 2'd2); chk("R1 addr reset", s0, 32'h0);
        // R2 / R3 partial data writes
        wr(4'h2, 2'd2, 32'h1122_3344);
        wr(4'h2, 2'd0, 32'hAABB_CCDD);
        peek(4'h2, 2'd2); chk("R2 byte merge", s0, 32'h1122_33DD);
        peek(4'h2, 2'd1); chk("R3 word view", s0, 32'h0000_33DD);
        wr(4'h2, 2'd1, 32'h0000_BEEF);
        peek(4'h2, 2'd2); chk("R2 word merge", s0, 32'h1122_BEEF);
        peek(4'h2, 2'd0); chk("R3 byte view", s0, 32'h0000_00EF);
        // R4 / R6 address registers
        wr(4'h9, 2'd1, 32'h0000_8001);
        peek(4'h9, 2'd2); chk("R4 sign extend neg", s0, 32'hFFFF_8001);
        peek(4'h9, 2'd1); chk("R6 addr word view", s0, 32'h0000_8001);
        wr(4'h9, 2'd2, 32'h1234_5678);
        wr_en = 1'b1; wr_sel = 4'h9; wr_size = 2'd0; wr_data = 32'hFFFF_FFFF;
        tick(); chk("R5 size_err raised", {31'b0, serr}, 32'h1);
        peek(4'h9, 2'd2); chk("R5 addr unchanged", s0, 32'h1234_5678);
        peek(4'h9, 2'd0); chk("R6 addr byte view", s0, 32'h0);
        wr(4'h9, 2'd1, 32'hFFFF_7FFF);
        peek(4'h9, 2'd2); chk("R4 sign extend pos", s0, 32'h0000_7FFF);
        // R7 swap
        wr(4'h5, 2'd2, 32'hCAFE_0001);
        swap_en = 1'b1; swap_sel = 3'd5; tick();
        peek(4'h5, 2'd2); chk("R7 swap", s0, 32'h0001_CAFE);
        // R8 write wins over swap, independent targets both apply
        wr_en = 1'b1; wr_sel = 4'h5; wr_size = 2'd2; wr_data = 32'h0102_0304;
        swap_en = 1'b1; swap_sel = 3'd5; tick();
        peek(4'h5, 2'd2); chk("R8 write wins", s0, 32'h0102_0304);
        wr_en = 1'b1; wr_sel = 4'h6; wr_size = 2'd2; wr_data = 32'hAAAA_5555;
        swap_en = 1'b1; swap_sel = 3'd5; tick();
        peek(4'h5, 2'd2); chk("R8 swap other", s0, 32'h0304_0102);
        peek(4'h6, 2'd2); chk("R8 write other", s0, 32'hAAAA_5555);
        // R9 read during write
        rd0_sel = 4'h7; rd0_size = 2'd2;
        wr(4'h7, 2'd2, 32'h0000_0077); chk("R9 old value", s0, 32'h0);
        peek(4'h7, 2'd2); chk("R9 new value", s0, 32'h0000_0077);
        // R10 bank select and reserved size
        wr(4'hB, 2'd2, 32'h0000_0033);
        peek(4'h3, 2'd2); chk("R10 data bank untouched", s0, 32'h0);
        peek(4'hB, 2'd2); chk("R10 addr bank written", s0, 32'h0000_0033);
        wr(4'h4, 2'd3, 32'hDEAD_BEEF);
        peek(4'h4, 2'd2); chk("R10 size3 as long", s0, 32'hDEAD_BEEF);
        // R11 two ports at once
        rd0_sel = 4'h2; rd0_size = 2'd2; rd1_sel = 4'h9; rd1_size = 2'd1; tick();
        chk("R11 port0", s0, 32'h1122_BEEF);
        chk("R11 port1", s1, 32'h0000_7FFF);
        // Pseudo-random sweep against the model
        for (int n = 0; n < 400; n++) begin
            rd0_sel = 4'($urandom); rd0_size = 2'($urandom);
            rd1_sel = 4'($urandom); rd1_size = 2'($urandom);
            wr_en = 1'($urandom); wr_sel = 4'($urandom); wr_size = 2'($urandom);
            wr_data = $urandom;
            swap_en = ($urandom % 4) == 0; swap_sel = 3'($urandom);
            tick();
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule